// File: doc/BRIEF.md
# Input Virtual Channel Route and Allocation Pipeline Control

This block controls one input virtual channel of a pipelined mesh router. A flit at the front of the channel's buffer moves into a one-slot intermediate stage. While in that stage, a head flit requests an output virtual channel. Every flit of a packet then requests the switch, using the output port stored for that packet. The route is computed on the head flit while it still waits at the front of the channel buffer. That computation overlaps the switch request of the previous packet's tail, so the channel can pass from one packet to the next without an idle cycle.

The stored output port is written only when a head flit enters the intermediate stage. A tail flit that loses switch allocation stays in the slot and retries with its stored port. During that time the waiting head cannot enter the slot, so the register holding the port stays frozen. The result of virtual-channel allocation is registered. A head flit granted a channel may request the switch in the following cycle, and never in the same cycle.

Top module: `ivc_rc_pipe`

## Requirements
- R1: After reset the intermediate slot is empty, and vaReq and saReq are low.
- R2: fifoDeq is high exactly when fifoValid is high and the slot is either empty or granted the switch in that cycle (saReq and saGrant both high). The dequeued flit appears on ebFlit, with ebValid high, in the next cycle.
- R3: The flit type is held in bits [1:0] (00 body, 01 head, 10 tail, 11 single-flit packet). The destination x is held in bits [2+:COORD_W] and the destination y in the next COORD_W bits. The route is dimension-order, x first, with ports encoded 0 local, 1 east (x larger), 2 west, 3 north (y larger) and 4 south.
- R4: outPort takes the route of a flit only when a head or single-flit packet enters the slot. Entries of body or tail flits leave it unchanged.
- R5: A flit that holds the slot and is not granted the switch stays in the slot with its content unchanged. It requests the switch again in the next cycle with the same outPort, and a waiting head is not dequeued.
- R6: A head in the slot without an allocated channel raises vaReq. After vaGrant, vaReq is low and saReq is high from the next cycle on, and saReq is never high in the grant cycle.
- R7: outVc captures vaGrantVc when vaReq and vaGrant are both high, and holds otherwise.
- R8: When a tail or single-flit packet wins the switch while the next head waits, that head enters the slot in the same cycle and raises vaReq in the next cycle.
- R9: Body and tail flits of a packet that already holds a channel request the switch on their first cycle in the slot, without vaReq.
- R10: saGrant while saReq is low and vaGrant while vaReq is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoValid | input | 1 | Front of the channel buffer holds a flit |
| fifoFlit | input | FLIT_W | Flit at the front of the channel buffer |
| fifoDeq | output | 1 | Pop the front flit into the slot |
| ebValid | output | 1 | Intermediate slot occupied |
| ebFlit | output | FLIT_W | Flit held in the slot |
| vaReq | output | 1 | Output channel request |
| vaGrant | input | 1 | Output channel grant |
| vaGrantVc | input | VC_W | Granted output channel id |
| outVc | output | VC_W | Stored output channel of the current packet |
| saReq | output | 1 | Switch request |
| saGrant | input | 1 | Switch grant |
| outPort | output | 3 | Stored output port of the current packet |

## Verification
A wrong slot-occupancy bit shows at fifoDeq in the same cycle: the block either drops a flit or pops into a full slot. A stale channel-allocated bit shows one cycle after a grant or a tail departure, as a missing saReq or a vaReq raised on a body flit. A port register that is overwritten early shows as a change in outPort in the first retry cycle after a tail loses the switch. A wrong route appears on outPort one cycle after the head enters the slot.

// File: rtl/ivc_pkg.sv
package ivc_pkg;
  localparam int PORT_W = 3;

  typedef enum logic [PORT_W-1:0] {
    PORT_LOCAL = 3'd0,
    PORT_EAST  = 3'd1,
    PORT_WEST  = 3'd2,
    PORT_NORTH = 3'd3,
    PORT_SOUTH = 3'd4
  } portId_e;

  // bit 0 marks a packet start, bit 1 marks a packet end
  typedef enum logic [1:0] {
    KIND_BODY   = 2'b00,
    KIND_HEAD   = 2'b01,
    KIND_TAIL   = 2'b10,
    KIND_SINGLE = 2'b11
  } flitKind_e;

  typedef struct packed {
    logic slotLoad;
    logic portLoad;
    logic vcLoad;
  } ivcStrobe_t;
endpackage

// File: rtl/ivc_route.sv
module ivc_route #(
  parameter int COORD_W = 2,
  parameter int HERE_X  = 1,
  parameter int HERE_Y  = 2
) (
  input  logic [COORD_W-1:0]          destX,
  input  logic [COORD_W-1:0]          destY,
  output logic [ivc_pkg::PORT_W-1:0]  port
);
  import ivc_pkg::*;
  localparam logic [COORD_W-1:0] hereX = COORD_W'(HERE_X);
  localparam logic [COORD_W-1:0] hereY = COORD_W'(HERE_Y);

  always_comb begin
    if (destX > hereX)      port = PORT_EAST;
    else if (destX < hereX) port = PORT_WEST;
    else if (destY > hereY) port = PORT_NORTH;
    else if (destY < hereY) port = PORT_SOUTH;
    else                    port = PORT_LOCAL;
  end
endmodule

// File: rtl/ivc_datapath.sv
module ivc_datapath #(
  parameter int COORD_W = 2,
  parameter int DATA_W  = 8,
  parameter int VC_W    = 2,
  parameter int HERE_X  = 1,
  parameter int HERE_Y  = 2,
  localparam int FLIT_W = 2 + 2*COORD_W + DATA_W
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ivc_pkg::ivcStrobe_t         strobe,
  input  logic [FLIT_W-1:0]           fifoFlit,
  input  logic [VC_W-1:0]             vaGrantVc,
  output logic [FLIT_W-1:0]           slotFlit,
  output logic [VC_W-1:0]             vcReg,
  output logic [ivc_pkg::PORT_W-1:0]  portReg
);
  import ivc_pkg::*;
  logic [PORT_W-1:0] rcPort;

  ivc_route #(.COORD_W(COORD_W), .HERE_X(HERE_X), .HERE_Y(HERE_Y)) uRoute (
    .destX(fifoFlit[2 +: COORD_W]),
    .destY(fifoFlit[2+COORD_W +: COORD_W]),
    .port (rcPort)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotFlit <= '0;
      vcReg    <= '0;
      portReg  <= PORT_LOCAL;
    end else begin
      if (strobe.slotLoad) slotFlit <= fifoFlit;
      if (strobe.portLoad) portReg  <= rcPort;
      if (strobe.vcLoad)   vcReg    <= vaGrantVc;
    end
  end
endmodule

// File: rtl/ivc_ctrl.sv
module ivc_ctrl (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fifoValid,
  input  logic [1:0]           fifoKind,
  input  logic [1:0]           slotKind,
  input  logic                 vaGrant,
  input  logic                 saGrant,
  output logic                 fifoDeq,
  output logic                 slotValid,
  output logic                 vaReq,
  output logic                 saReq,
  output ivc_pkg::ivcStrobe_t  strobe
);
  logic vcHeld;
  logic saWin;
  logic slotFree;

  always_comb begin
    vaReq    = slotValid && !vcHeld;
    saReq    = slotValid && vcHeld;
    saWin    = saReq && saGrant;
    slotFree = !slotValid || saWin;
    fifoDeq  = fifoValid && slotFree;
    strobe.slotLoad = fifoDeq;
    // the port register only moves when a new packet takes the slot
    strobe.portLoad = fifoDeq && fifoKind[0];
    strobe.vcLoad   = vaReq && vaGrant;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotValid <= 1'b0;
      vcHeld    <= 1'b0;
    end else begin
      if (fifoDeq)    slotValid <= 1'b1;
      else if (saWin) slotValid <= 1'b0;

      if (saWin && slotKind[1]) vcHeld <= 1'b0;
      else if (strobe.vcLoad)   vcHeld <= 1'b1;
    end
  end
endmodule

// File: rtl/ivc_rc_pipe.sv
module ivc_rc_pipe #(
  parameter int COORD_W = 2,
  parameter int DATA_W  = 8,
  parameter int VC_W    = 2,
  parameter int HERE_X  = 1,
  parameter int HERE_Y  = 2,
  localparam int FLIT_W = 2 + 2*COORD_W + DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoValid,
  input  logic [FLIT_W-1:0] fifoFlit,
  output logic              fifoDeq,
  output logic              ebValid,
  output logic [FLIT_W-1:0] ebFlit,
  output logic              vaReq,
  input  logic              vaGrant,
  input  logic [VC_W-1:0]   vaGrantVc,
  output logic [VC_W-1:0]   outVc,
  output logic              saReq,
  input  logic              saGrant,
  output logic [2:0]        outPort
);
  import ivc_pkg::*;
  ivcStrobe_t strobe;

  ivc_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .fifoValid(fifoValid), .fifoKind(fifoFlit[1:0]), .slotKind(ebFlit[1:0]),
    .vaGrant(vaGrant), .saGrant(saGrant),
    .fifoDeq(fifoDeq), .slotValid(ebValid),
    .vaReq(vaReq), .saReq(saReq), .strobe(strobe)
  );

  ivc_datapath #(.COORD_W(COORD_W), .DATA_W(DATA_W), .VC_W(VC_W),
                 .HERE_X(HERE_X), .HERE_Y(HERE_Y)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .fifoFlit(fifoFlit), .vaGrantVc(vaGrantVc),
    .slotFlit(ebFlit), .vcReg(outVc), .portReg(outPort)
  );
endmodule

// File: rtl/ivc_rc_pipe_chk.sv
module ivc_rc_pipe_chk #(
  parameter int FLIT_W = 14,
  parameter int VC_W   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              fifoValid,
  input logic [FLIT_W-1:0] fifoFlit,
  input logic              fifoDeq,
  input logic              ebValid,
  input logic [FLIT_W-1:0] ebFlit,
  input logic              vaReq,
  input logic              vaGrant,
  input logic [VC_W-1:0]   outVc,
  input logic              saReq,
  input logic              saGrant,
  input logic [2:0]        outPort
);
  // R2
  deq_needs_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoDeq |-> fifoValid);
  // R2
  deq_fills_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoDeq |=> ebValid && ebFlit == $past(fifoFlit));
  // R5
  loser_stays_chk: assert property (@(posedge clk) disable iff (!rstN)
    ebValid && !(saReq && saGrant) |=> ebValid && $stable(ebFlit) && $stable(outPort));
  // R5
  loser_blocks_deq_chk: assert property (@(posedge clk) disable iff (!rstN)
    ebValid && !(saReq && saGrant) |-> !fifoDeq);
  // R6
  no_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    vaReq && vaGrant |=> saReq && !vaReq);
  // R7
  vc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(vaReq && vaGrant) |=> $stable(outVc));
  // R8
  next_head_va_chk: assert property (@(posedge clk) disable iff (!rstN)
    saReq && saGrant && ebFlit[1] && fifoValid && fifoFlit[0] |=> vaReq);
  // R4
  body_keeps_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoDeq && fifoFlit[0]) |=> $stable(outPort));
endmodule

bind ivc_rc_pipe ivc_rc_pipe_chk #(.FLIT_W(FLIT_W), .VC_W(VC_W)) uChk (
  .clk(clk), .rstN(rstN), .fifoValid(fifoValid), .fifoFlit(fifoFlit),
  .fifoDeq(fifoDeq), .ebValid(ebValid), .ebFlit(ebFlit), .vaReq(vaReq),
  .vaGrant(vaGrant), .outVc(outVc), .saReq(saReq), .saGrant(saGrant),
  .outPort(outPort)
);

// File: tb/ivc_rc_pipe_test.sv
`timescale 1ns/1ps
module ivc_rc_pipe_test;
  localparam int CW = 2, DW = 8, VW = 2, HX = 1, HY = 2;
  localparam int FW = 2 + 2*CW + DW;

  logic clk = 1'b0, rstN = 1'b0;
  logic fifoValid = 1'b0, vaGrant = 1'b0, saGrant = 1'b0;
  logic [FW-1:0] fifoFlit = '0;
  logic [VW-1:0] vaGrantVc = '0;
  logic fifoDeq, ebValid, vaReq, saReq;
  logic [FW-1:0] ebFlit;
  logic [VW-1:0] outVc;
  logic [2:0] outPort;
  int total = 0, bad = 0, cycles = 0;

  always #5 clk = ~clk;

  ivc_rc_pipe #(.COORD_W(CW), .DATA_W(DW), .VC_W(VW), .HERE_X(HX), .HERE_Y(HY)) uut (
    .clk(clk), .rstN(rstN), .fifoValid(fifoValid), .fifoFlit(fifoFlit),
    .fifoDeq(fifoDeq), .ebValid(ebValid), .ebFlit(ebFlit), .vaReq(vaReq),
    .vaGrant(vaGrant), .vaGrantVc(vaGrantVc), .outVc(outVc), .saReq(saReq),
    .saGrant(saGrant), .outPort(outPort)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk(input int kind, input int x, input int y, input int d);
    return {DW'(d), CW'(y), CW'(x), 2'(kind)};
  endfunction

  function automatic int route(input int x, input int y);
    if (x > HX) return 1;
    if (x < HX) return 2;
    if (y > HY) return 3;
    if (y < HY) return 4;
    return 0;
  endfunction

  // drive at the falling edge, then look at combinational outputs
  task automatic step(input logic fv, input logic [FW-1:0] ff, input logic vg,
                      input int vc, input logic sg);
    @(negedge clk);
    fifoValid = fv; fifoFlit = ff; vaGrant = vg; vaGrantVc = VW'(vc); saGrant = sg;
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 ebValid", ebValid, 0);
    check("R1 vaReq", vaReq, 0);
    check("R1 saReq", saReq, 0);
    rstN = 1'b1;

    // sweep every destination with single-flit packets
    for (int x = 0; x < 4; x++) begin
      for (int y = 0; y < 4; y++) begin
        step(1, mk(3, x, y, x*4+y), 0, 0, 0);
        check("R2 deq into empty slot", fifoDeq, 1);
        step(0, '0, 1, x ^ y, 0);
        check("R2 slot filled", ebValid, 1);
        check("R2 slot content", int'(ebFlit), int'(mk(3, x, y, x*4+y)));
        check("R3 route", outPort, route(x, y));
        check("R6 va request", vaReq, 1);
        check("R6 no same-cycle sa", saReq, 0);
        step(0, '0, 0, 0, 1);
        check("R6 sa after grant", saReq, 1);
        check("R6 va dropped", vaReq, 0);
        check("R7 vc captured", outVc, x ^ y);
        step(0, '0, 0, 0, 0);
        check("R2 slot emptied", ebValid, 0);
      end
    end

    // multi-flit packet, tail loses once, next head waits
    step(1, mk(1, 3, 0, 1), 0, 0, 0);             // c0 head to east
    check("R2 head deq", fifoDeq, 1);
    step(1, mk(0, 0, 0, 2), 1, 2, 1);             // c1 head in slot, sa grant ignored
    check("R10 stray sa grant", fifoDeq, 0);
    check("R6 head va", vaReq, 1);
    check("R3 east", outPort, 1);
    step(1, mk(0, 0, 0, 2), 0, 0, 1);             // c2
    check("R10 slot kept head", int'(ebFlit), int'(mk(1, 3, 0, 1)));
    check("R6 head sa", saReq, 1);
    check("R2 deq on win", fifoDeq, 1);
    step(1, mk(2, 0, 3, 3), 1, 1, 1);             // c3 body, stray va grant
    check("R9 body sa", saReq, 1);
    check("R9 body no va", vaReq, 0);
    check("R4 body keeps port", outPort, 1);
    step(1, mk(1, 1, 0, 4), 0, 0, 0);             // c4 tail loses, head waits
    check("R10 stray va grant", outVc, 2);
    check("R9 tail sa", saReq, 1);
    check("R5 head blocked", fifoDeq, 0);
    check("R4 tail keeps port", outPort, 1);
    step(1, mk(1, 1, 0, 4), 0, 0, 1);             // c5 tail retries and wins
    check("R5 tail still held", int'(ebFlit), int'(mk(2, 0, 3, 3)));
    check("R5 tail retries", saReq, 1);
    check("R5 port frozen", outPort, 1);
    check("R8 head deq same cycle", fifoDeq, 1);
    step(0, '0, 0, 0, 0);                         // c6
    check("R8 head va next cycle", vaReq, 1);
    check("R8 head sa low", saReq, 0);
    check("R4 new port", outPort, 4);
    check("R7 vc held", outVc, 2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule